// File: doc/BRIEF.md
# Serial Register Access Port

This block lets an external host read and write a 128-entry, 8-bit-wide register space over a four-wire serial link. The link uses an active-low select, a serial clock, a data input and a data output. Every transfer is a fixed 16-clock frame. The host sends a write-enable flag, a 7-bit address and one data byte. On the same frame the block sends back a status header and one data byte.

The returned byte always belongs to the access made by the previous valid frame. It is not taken from the frame in progress. A host therefore reads a register by sending a read frame for that address and then sending any other frame to collect the value.

The block runs entirely on a system clock that is at least four times faster than the serial clock. All three link inputs pass through synchronizer flops. The frame length is checked when select is released. Any frame that did not see exactly 16 rising serial-clock edges is dropped, and an error flag is raised in the header of the next frame.

Top module: `spi_reg_slave`

## Requirements
- R1: While reset is active and in the first cycle after it: `so_oe`=0, `reg_we`=0, `reg_addr`=0. The held read byte is cleared to 0.
- R2: `so_oe` is 1 while the synchronized `csb_n` is low and 0 while it is high. This means SO is undriven whenever the host has not selected the block.
- R3: A frame with exactly 16 rising `sclk` edges and a first bit of 1 gives exactly one `reg_we` pulse after `csb_n` rises. With that pulse, `reg_addr` equals bits 2..8 and `reg_wdata` equals bits 9..16, both sent MSB first.
- R4: A 16-edge frame with a first bit of 0 updates `reg_addr` to its address field and gives no `reg_we` pulse.
- R5: The first 7 SO bits of a frame are the status word, MSB first. Slot 1 is the frame-error flag and slots 2..7 are `host_status[5:0]`. Slot 8 is always 0.
- R6: SO slots 9..16 carry, MSB first, the register content at the address of the previous valid frame. This is the content after that frame's own write. The byte is 0 if no valid frame has occurred since reset.
- R7: A frame with any other count of rising edges (0, fewer than 16, or more than 16) gives no `reg_we` and leaves `reg_addr` unchanged. It sets the frame-error flag, and the flag is reported in slot 1 of the next frame.
- R8: A valid 16-edge frame clears the frame-error flag. The frame after it reports 0 in slot 1.
- R9: `reg_we` is never high for two consecutive cycles.
- R10: SI is sampled at the rising edge of `sclk`. SO advances at the falling edge. The first SO bit is present once select is low and before the first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| csb_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data from the host |
| so_data | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for SO; 0 means high impedance |
| reg_addr | output | 7 | Register address of the last valid frame |
| reg_wdata | output | 8 | Write data of the last valid write frame |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Register content at `reg_addr`, one cycle write latency |
| host_status | input | 6 | Status bits reported in the frame header |

## Verification
The bit counter and the error flag are internal state, and a wrong value in either shows at the ports within one frame. A miscount either suppresses or wrongly issues the write strobe when select rises. The error flag appears in slot 1 of the very next header. A stale or mistimed capture of the held read byte shows up as a wrong value in the last 8 SO bits of the following frame. The SO word is compared bit by bit against a model that tracks register contents, the last valid address and the error flag. This catches a shift or ordering error in the first frame where it occurs.

// File: rtl/spi_acc_pkg.sv
package spi_acc_pkg;

    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 8;
    localparam int HSTAT_W   = ADDR_W - 1;
    localparam int FRAME_LEN = 1 + ADDR_W + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 2);
    localparam int CNT_SAT   = FRAME_LEN + 1;
    localparam int SYNC_LEN  = 2;
    // cycles from write strobe to read-byte capture (register file writes one cycle late)
    localparam int RD_LAT    = 2;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic               ferr;
        logic [HSTAT_W-1:0] host;
        logic               pad;
        logic [DATA_W-1:0]  rd;
    } reply_t;

    typedef enum logic [0:0] {
        LINK_IDLE   = 1'b0,
        LINK_ACTIVE = 1'b1
    } link_state_e;

    function automatic reply_t build_reply(input logic ferr,
                                           input logic [HSTAT_W-1:0] host,
                                           input logic [DATA_W-1:0] rd);
        reply_t r;
        r.ferr = ferr;
        r.host = host;
        r.pad  = 1'b0;
        r.rd   = rd;
        return r;
    endfunction

endpackage

// File: rtl/spi_acc_sync.sv
module spi_acc_sync #(
    parameter int               WIDTH     = 1,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) pipe <= RESET_VAL;
                else     pipe <= d_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) pipe <= {STAGES{RESET_VAL}};
                else     pipe <= {pipe[STAGES-2:0], d_in};
            end
        end
    endgenerate

    assign d_out = pipe[STAGES-1];
endmodule

// File: rtl/spi_acc_rx.sv
module spi_acc_rx
    import spi_acc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sel_start,
    input  logic   sel_end,
    input  logic   bit_strobe,
    input  logic   bit_val,
    output logic   frame_ok,
    output logic   frame_bad,
    output frame_t frame_q
);
    logic [FRAME_LEN-1:0] shreg;
    logic [CNT_W-1:0]     cnt;
    link_state_e          st;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            cnt       <= '0;
            st        <= LINK_IDLE;
            frame_ok  <= 1'b0;
            frame_bad <= 1'b0;
        end else begin
            frame_ok  <= 1'b0;
            frame_bad <= 1'b0;
            case (st)
                LINK_IDLE: begin
                    if (sel_start) begin
                        cnt <= '0;
                        st  <= LINK_ACTIVE;
                    end
                end
                default: begin
                    if (sel_end) begin
                        st <= LINK_IDLE;
                        if (cnt == CNT_W'(FRAME_LEN)) frame_ok  <= 1'b1;
                        else                          frame_bad <= 1'b1;
                    end else if (bit_strobe) begin
                        shreg <= {shreg[FRAME_LEN-2:0], bit_val};
                        if (cnt != CNT_W'(CNT_SAT)) cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign frame_q = frame_t'(shreg);
endmodule

// File: rtl/spi_acc_tx.sv
module spi_acc_tx
    import spi_acc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  logic   advance,
    input  reply_t word,
    output logic   so_bit
);
    localparam int TX_W = $bits(reply_t);

    logic [TX_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst)          shreg <= '0;
        else if (load)    shreg <= word;
        else if (advance) shreg <= {shreg[TX_W-2:0], 1'b0};
    end

    assign so_bit = shreg[TX_W-1];
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_acc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               csb_n,
    input  logic               sclk,
    input  logic               si,
    output logic               so_data,
    output logic               so_oe,
    output logic [ADDR_W-1:0]  reg_addr,
    output logic [DATA_W-1:0]  reg_wdata,
    output logic               reg_we,
    input  logic [DATA_W-1:0]  reg_rdata,
    input  logic [HSTAT_W-1:0] host_status
);
    logic [2:0] raw_in, sync_out;
    logic       csb_s, sclk_s, si_s;
    logic       csb_d, sclk_d;
    logic       sel_start, sel_end, clk_rise, clk_fall;
    logic       frame_ok, frame_bad;
    frame_t     frame_q;
    logic       ferr;
    logic [RD_LAT-1:0] cap_pipe;
    logic [DATA_W-1:0] rd_hold;
    reply_t     reply;

    assign raw_in = {csb_n, sclk, si};

    spi_acc_sync #(
        .WIDTH    (3),
        .STAGES   (SYNC_LEN),
        .RESET_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d_in (raw_in),
        .d_out(sync_out)
    );

    assign {csb_s, sclk_s, si_s} = sync_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            csb_d  <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            csb_d  <= csb_s;
            sclk_d <= sclk_s;
        end
    end

    assign sel_start = csb_d & ~csb_s;
    assign sel_end   = ~csb_d & csb_s;
    assign clk_rise  = ~sclk_d & sclk_s & ~csb_s;
    assign clk_fall  = sclk_d & ~sclk_s & ~csb_s;

    spi_acc_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .sel_start (sel_start),
        .sel_end   (sel_end),
        .bit_strobe(clk_rise),
        .bit_val   (si_s),
        .frame_ok  (frame_ok),
        .frame_bad (frame_bad),
        .frame_q   (frame_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_we    <= 1'b0;
            ferr      <= 1'b0;
            cap_pipe  <= '0;
            rd_hold   <= '0;
        end else begin
            reg_we   <= 1'b0;
            cap_pipe <= {cap_pipe[RD_LAT-2:0], frame_ok};
            if (frame_ok) begin
                reg_addr  <= frame_q.addr;
                reg_wdata <= frame_q.data;
                reg_we    <= frame_q.we;
                ferr      <= 1'b0;
            end else if (frame_bad) begin
                ferr <= 1'b1;
            end
            if (cap_pipe[RD_LAT-1]) rd_hold <= reg_rdata;
        end
    end

    assign reply = build_reply(ferr, host_status, rd_hold);

    spi_acc_tx u_tx (
        .clk    (clk),
        .rst    (rst),
        .load   (sel_start),
        .advance(clk_fall),
        .word   (reply),
        .so_bit (so_data)
    );

    assign so_oe = ~csb_s;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
    import spi_acc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              csb_n,
    input logic              so_oe,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr
);
    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 1'b1;
    end

    // R9: the write strobe lasts one cycle
    assert_we_single_R9: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R3: a strobe only follows a released select
    assert_we_after_release_R3: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd2 && reg_we) |-> $past(csb_n));

    // R2: SO undriven once select has been high long enough to pass the synchronizer
    assert_oe_off_R2: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd4 && csb_n && $past(csb_n) && $past(csb_n, 2) && $past(csb_n, 3))
        |-> !so_oe);

    // R2: SO driven once select has been low long enough
    assert_oe_on_R2: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd4 && !csb_n && !$past(csb_n) && !$past(csb_n, 2) && !$past(csb_n, 3))
        |-> so_oe);

    // R4: address stays put while a frame is in progress
    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd4 && !csb_n && !$past(csb_n) && !$past(csb_n, 2) && !$past(csb_n, 3))
        |-> $stable(reg_addr));
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .csb_n   (csb_n),
    .so_oe   (so_oe),
    .reg_we  (reg_we),
    .reg_addr(reg_addr)
);

// File: tb/tb_spi_reg_slave.sv
module tb_spi_reg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int NVEC       = 11;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       csb_n = 1'b1;
    logic       sclk = 1'b0;
    logic       si = 1'b0;
    logic       so_data, so_oe, reg_we;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [5:0] host_status = '0;

    logic [7:0] rf [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_reg_slave dut (
        .clk(clk), .rst(rst), .csb_n(csb_n), .sclk(sclk), .si(si),
        .so_data(so_data), .so_oe(so_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
        .host_status(host_status)
    );

    // external register file: one cycle write latency, combinational read
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 128; i++) rf[i] <= 8'h00;
        end else if (reg_we) begin
            rf[reg_addr] <= reg_wdata;
        end
    end
    assign reg_rdata = rf[reg_addr];

    int         we_count;
    logic [6:0] we_addr;
    logic [7:0] we_data;
    always @(posedge clk) begin
        if (!rst && reg_we) begin
            we_count <= we_count + 1;
            we_addr  <= reg_addr;
            we_data  <= reg_wdata;
        end
    end

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {we, addr, data, len}
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b1, 7'h05, 8'h3C, 5'd16},
        {1'b0, 7'h05, 8'h00, 5'd16},
        {1'b1, 7'h7F, 8'hA5, 5'd16},
        {1'b1, 7'h10, 8'hFF, 5'd12},
        {1'b0, 7'h7F, 8'h00, 5'd16},
        {1'b1, 7'h00, 8'h81, 5'd17},
        {1'b1, 7'h00, 8'h81, 5'd16},
        {1'b0, 7'h10, 8'h00, 5'd16},
        {1'b0, 7'h00, 8'h00, 5'd16},
        {1'b0, 7'h22, 8'h00, 5'd0},
        {1'b0, 7'h05, 8'h00, 5'd16}
    };

    // bench model
    logic [7:0] m_rf [128];
    logic [6:0] m_last_addr;
    logic       m_err;
    logic [7:0] m_hold;

    task automatic run_frame(input logic [15:0] word, input int len, input logic [5:0] stat,
                             output logic [15:0] got);
        got = '0;
        @(negedge clk);
        host_status = stat;
        csb_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int b = 0; b < len; b++) begin
            si = (b < 16) ? word[15-b] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (b < 16) got[15-b] = so_data;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        csb_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] got, exp_word;
        logic [15:0] mask;
        we_count = 0;
        for (int i = 0; i < 128; i++) m_rf[i] = 8'h00;
        m_last_addr = '0; m_err = 1'b0; m_hold = 8'h00;

        repeat (3) @(negedge clk);
        // R1: reset values
        check(so_oe == 1'b0, "R1 so_oe in reset", so_oe, 0);
        check(reg_we == 1'b0, "R1 reg_we in reset", reg_we, 0);
        check(reg_addr == 7'h00, "R1 reg_addr in reset", reg_addr, 0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        check(so_oe == 1'b0, "R2 so_oe idle", so_oe, 0);

        for (int v = 0; v < NVEC; v++) begin
            logic       we;
            logic [6:0] ad;
            logic [7:0] dt;
            int         len;
            logic [5:0] st;
            int         wc0;
            {we, ad, dt} = VEC[v][20:5];
            len = int'(VEC[v][4:0]);
            st  = 6'h2A ^ 6'(v * 5);
            exp_word = {m_err, st, 1'b0, m_hold};
            wc0 = we_count;
            run_frame({we, ad, dt}, len, st, got);

            // R5 R6 R10: compare the SO bits that were clocked
            mask = (len >= 16) ? 16'hFFFF : ~(16'hFFFF >> len);
            check((got & mask) == (exp_word & mask), "R5/R6 SO word", got & mask, exp_word & mask);

            if (len == 16) begin
                m_err = 1'b0;
                m_last_addr = ad;
                if (we) m_rf[ad] = dt;
                m_hold = m_rf[ad];
                if (we) begin
                    check(we_count == wc0 + 1, "R3 one strobe", we_count - wc0, 1);
                    check(we_addr == ad && we_data == dt, "R3 strobe addr/data", {we_addr, we_data}, {ad, dt});
                end else begin
                    check(we_count == wc0, "R4 no strobe on read", we_count - wc0, 0);
                end
            end else begin
                m_err = 1'b1;
                check(we_count == wc0, "R7 no strobe on bad frame", we_count - wc0, 0);
            end
            check(reg_addr == m_last_addr, "R4/R7 reg_addr", reg_addr, m_last_addr);
        end

        // R8: flag from vector 9 reported by vector 10, cleared now
        begin
            logic [15:0] g2;
            run_frame(16'h0000, 16, 6'h00, g2);
            check(g2[15] == 1'b0, "R8 error flag cleared", g2[15], 0);
            check(g2[7:0] == m_rf[7'h05], "R6 data from previous access", g2[7:0], m_rf[7'h05]);
        end

        // R2: SO driven mid-frame
        @(negedge clk);
        csb_n = 1'b0;
        repeat (6) @(negedge clk);
        check(so_oe == 1'b1, "R2 so_oe selected", so_oe, 1);
        csb_n = 1'b1;
        repeat (12) @(negedge clk);
        check(so_oe == 1'b0, "R2 so_oe released", so_oe, 0);

        // R1: mid-run reset clears the held byte and the flag
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(so_oe == 1'b0 && reg_we == 1'b0 && reg_addr == 7'h00, "R1 re-reset",
              {so_oe, reg_we, reg_addr}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        run_frame({1'b0, 7'h05, 8'h00}, 16, 6'h15, got);
        check(got == {1'b0, 6'h15, 1'b0, 8'h00}, "R1/R5 header after reset", got, {1'b0, 6'h15, 1'b0, 8'h00});

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule